// File: doc/BRIEF.md
# Serial Bus Bit Sampler

This block turns one asynchronous receive line of a differential field bus into a stream of sampled bit values. The line passes through a short synchroniser first. While the block is idle it waits for the first dominant (logic 0) level. The clock edge that sees that level becomes the frame reference. From then on the block takes one sample per nominal bit period, and each sample lands a fixed fraction of the way into its bit. Every later sample position is an absolute offset from the single reference. No resynchronisation takes place on later edges.

A downstream frame parser consumes the strobed bits, stuff bits included. It pulses a frame-done input when it recognises the end of a frame. That pulse sends the sampler back to idle so it can hard-sync on the next frame. The bit period and the sample-point fraction are captured at the start of each frame. They may therefore be reprogrammed between frames without disturbing a frame in progress.

Top module: `bus_bit_sampler`

## Requirements
- R1: After reset `bit_strobe` is 0, `bit_value` is 0, `bit_index` is 0 and the block is idle.
- R2: While idle, a recessive (1) synchronised line produces no strobe, and a `frame_done` pulse has no effect.
- R3: The raw line passes through `SYNC_STAGES` flip-flops (default 2) before any decision. The first clock edge at which the synchronised line reads 0 in idle is the frame reference edge.
- R4: Bit n of a frame is sampled at reference edge + n*P + floor(P*F/256). P is `bit_cycles` and F is `sample_frac` in units of 1/256 of a bit. `bit_strobe` is high in the cycle after that edge.
- R5: With each strobe, `bit_value` carries the synchronised line value at the sampling edge and `bit_index` carries n. n counts every sampled bit, stuff bits included, and wraps at 2^IDX_W. Both outputs hold between strobes.
- R6: Each strobe lasts exactly one clock cycle. `bit_cycles` must be at least 2.
- R7: P and the sample offset are captured on the reference edge. Changes to `bit_cycles` or `sample_frac` during a frame do not alter that frame's sample positions.
- R8: `frame_done` high at a clock edge while a frame runs returns the block to idle at that edge and suppresses any strobe at that edge. The next frame restarts at n = 0 with a new reference.
- R9: When the offset is 0, bit 0 is sampled on the reference edge itself, with value 0 and index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Raw bus receive line, 0 dominant, 1 recessive |
| bit_cycles | input | CYC_W (12) | Clock cycles per nominal bit (at least 2) |
| sample_frac | input | FRAC_W (8) | Sample point as a fraction of the bit, in 1/256 steps |
| frame_done | input | 1 | End-of-frame pulse from the parser |
| bit_strobe | output | 1 | One-cycle pulse per sampled bit |
| bit_value | output | 1 | Value of the last sampled bit |
| bit_index | output | IDX_W (8) | Position of the last sampled bit within the frame |

## Verification
Two situations are hard to reach from the ports. The first is a `frame_done` pulse that lands on exactly the edge where a sample is due. The bench tracks the edge count and the known sample schedule of the running frame, and it raises `frame_done` in the half cycle just before that edge. The second is a change of `bit_cycles` and `sample_frac` while a frame runs. The bench makes that change after a few bits and measures the spacing of the following strobes. A behavioural model then compares all three outputs on every cycle, across frames with zero and non-zero offsets and with a longer pseudo-random bit pattern.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } bbs_state_e;

endpackage

// File: rtl/bbs_line_sync.sv
module bbs_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign line_out = line_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q[0] <= line_in;
               for (int i = 1; i < STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign line_out = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bbs_offset_calc.sv
module bbs_offset_calc #(
   parameter int CYC_W     = 12,
   parameter int FRAC_W    = 8,
   parameter int MUL_STYLE = 0
) (
   input  logic [CYC_W-1:0]  period,
   input  logic [FRAC_W-1:0] frac,
   output logic [CYC_W-1:0]  offset
);

   localparam int PROD_W = CYC_W + FRAC_W;

   logic [PROD_W-1:0] prod;

   generate
      if (MUL_STYLE == 0) begin : g_mult
         assign prod = PROD_W'(period) * PROD_W'(frac);
      end else begin : g_shift_add
         logic [PROD_W-1:0] part [FRAC_W];
         for (genvar i = 0; i < FRAC_W; i++) begin : g_part
            assign part[i] = frac[i] ? (PROD_W'(period) << i) : '0;
         end
         always_comb begin
            prod = '0;
            for (int j = 0; j < FRAC_W; j++) begin
               prod = prod + part[j];
            end
         end
      end
   endgenerate

   assign offset = CYC_W'(prod >> FRAC_W);

   always_comb begin
      if (period != '0) begin
         a_offset_below_period_r4 : assert (offset < period)
            else $error("sample offset not inside bit period");
      end
   end

endmodule

// File: rtl/bus_bit_sampler.sv
module bus_bit_sampler
   import bbs_pkg::*;
#(
   parameter int CYC_W       = 12,
   parameter int FRAC_W      = 8,
   parameter int IDX_W       = 8,
   parameter int CNT_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter int MUL_STYLE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic [CYC_W-1:0]  bit_cycles,
   input  logic [FRAC_W-1:0] sample_frac,
   input  logic              frame_done,
   output logic              bit_strobe,
   output logic              bit_value,
   output logic [IDX_W-1:0]  bit_index
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (CNT_W < CYC_W + 4) begin : g_bad_cnt
         $error("CNT_W too narrow for the bit period");
      end
      if (FRAC_W < 1 || IDX_W < 1) begin : g_bad_width
         $error("FRAC_W and IDX_W must be positive");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_mul
         $error("MUL_STYLE must be 0 or 1");
      end
   endgenerate

   logic             line_s;
   logic [CYC_W-1:0] offset_now;

   bbs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (rx_line),
      .line_out (line_s)
   );

   bbs_offset_calc #(
      .CYC_W     (CYC_W),
      .FRAC_W    (FRAC_W),
      .MUL_STYLE (MUL_STYLE)
   ) u_offset (
      .period (bit_cycles),
      .frac   (sample_frac),
      .offset (offset_now)
   );

   bbs_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target_q;
   logic [CYC_W-1:0] period_q;
   logic [IDX_W-1:0] next_idx_q;
   logic             strobe_q;
   logic             value_q;
   logic [IDX_W-1:0] index_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         target_q   <= '0;
         period_q   <= '0;
         next_idx_q <= '0;
         strobe_q   <= 1'b0;
         value_q    <= 1'b0;
         index_q    <= '0;
      end else begin
         strobe_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (!line_s) begin
                  state_q  <= ST_RUN;
                  period_q <= bit_cycles;
                  cnt_q    <= CNT_ONE;
                  if (offset_now == '0) begin
                     strobe_q   <= 1'b1;
                     value_q    <= line_s;
                     index_q    <= '0;
                     next_idx_q <= IDX_W'(1);
                     target_q   <= CNT_W'(bit_cycles);
                  end else begin
                     next_idx_q <= '0;
                     target_q   <= CNT_W'(offset_now);
                  end
               end
            end
            ST_RUN: begin
               if (frame_done) begin
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q + CNT_ONE;
                  if (cnt_q == target_q) begin
                     strobe_q   <= 1'b1;
                     value_q    <= line_s;
                     index_q    <= next_idx_q;
                     next_idx_q <= next_idx_q + IDX_W'(1);
                     target_q   <= target_q + CNT_W'(period_q);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bit_strobe = strobe_q;
   assign bit_value  = value_q;
   assign bit_index  = index_q;

   // R6: a strobe never lasts two cycles once a legal period is captured
   p_strobe_single_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_q && period_q >= CYC_W'(2)) |=> !strobe_q);

   // R8: frame end during a frame forces idle with no strobe on that edge
   p_done_to_idle_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && frame_done) |=> (state_q == ST_IDLE && !strobe_q));

   // R2: recessive line in idle keeps the block idle and quiet
   p_idle_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && line_s) |=> (state_q == ST_IDLE && !strobe_q));

   // R7: captured period is frozen for the whole frame
   p_period_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !frame_done) |=> $stable(period_q));

   // R4: the next sample position never falls behind the elapsed count
   p_target_ahead_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |-> (target_q >= cnt_q));

endmodule

// File: tb/bus_bit_sampler_bench.sv
module bus_bit_sampler_bench;

   localparam int CYC_W  = 12;
   localparam int FRAC_W = 8;
   localparam int IDX_W  = 8;
   localparam int SYNC   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_line = 1'b1;
   logic [CYC_W-1:0]  bit_cycles = 12'd10;
   logic [FRAC_W-1:0] sample_frac = 8'd179;
   logic              frame_done = 1'b0;
   logic              bit_strobe;
   logic              bit_value;
   logic [IDX_W-1:0]  bit_index;

   always #2.5 clk = ~clk;

   bus_bit_sampler #(
      .CYC_W (CYC_W), .FRAC_W (FRAC_W), .IDX_W (IDX_W), .SYNC_STAGES (SYNC)
   ) u_bus_bit_sampler (
      .clk (clk), .rst_n (rst_n), .rx_line (rx_line),
      .bit_cycles (bit_cycles), .sample_frac (sample_frac),
      .frame_done (frame_done), .bit_strobe (bit_strobe),
      .bit_value (bit_value), .bit_index (bit_index)
   );

   int errs = 0;
   int checks = 0;
   int edge_cnt = 0;
   bit monitor_on = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic rxq[$];
   bit   m_run = 1'b0;
   int   m_ref, m_per, m_off, m_n;
   bit   e_strobe = 1'b0;
   bit   e_val = 1'b0;
   int   e_idx = 0;

   always @(posedge clk) begin
      edge_cnt++;
      if (!rst_n) begin
         rxq.delete();
         m_run = 1'b0; e_strobe = 1'b0; e_val = 1'b0; e_idx = 0;
      end else begin
         logic s;
         s = (rxq.size() >= SYNC) ? rxq[rxq.size()-SYNC] : 1'b1;
         rxq.push_back(rx_line);
         if (rxq.size() > 6) void'(rxq.pop_front());
         e_strobe = 1'b0;
         if (!m_run) begin
            if (s == 1'b0) begin
               m_run = 1'b1; m_ref = edge_cnt; m_n = 0;
               m_per = int'(bit_cycles);
               m_off = (int'(bit_cycles) * int'(sample_frac)) / 256;
               if (m_off == 0) begin
                  e_strobe = 1'b1; e_val = s; e_idx = 0; m_n = 1;
               end
            end
         end else if (frame_done) begin
            m_run = 1'b0;
         end else if (edge_cnt - m_ref == m_n * m_per + m_off) begin
            e_strobe = 1'b1; e_val = s; e_idx = m_n % 256; m_n++;
         end
      end
   end

   // ---------------- monitor: every-cycle compare ----------------
   int s_edge[$];
   int s_val[$];
   int s_idx[$];

   always @(negedge clk) begin
      if (monitor_on) begin
         chk(bit_strobe == e_strobe, "R4 strobe", int'(bit_strobe), int'(e_strobe));
         chk(bit_value == e_val, "R5 value", int'(bit_value), int'(e_val));
         chk(int'(bit_index) == e_idx, "R5 index", int'(bit_index), e_idx);
         if (bit_strobe) begin
            s_edge.push_back(edge_cnt);
            s_val.push_back(int'(bit_value));
            s_idx.push_back(int'(bit_index));
         end
      end
   end

   task automatic clear_log();
      s_edge.delete(); s_val.delete(); s_idx.delete();
   endtask

   task automatic send_bits(input logic [63:0] pat, input int nbits, input int per);
      for (int i = 0; i < nbits; i++) begin
         rx_line = pat[nbits-1-i];
         repeat (per) @(negedge clk);
      end
   endtask

   task automatic pulse_done();
      frame_done = 1'b1;
      @(negedge clk);
      frame_done = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      int d;
      int mingap;
      logic [63:0] pat;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(bit_strobe == 1'b0, "R1 strobe", int'(bit_strobe), 0);
      chk(bit_value == 1'b0, "R1 value", int'(bit_value), 0);
      chk(bit_index == '0, "R1 index", int'(bit_index), 0);
      rst_n = 1'b1;
      monitor_on = 1'b1;

      // R2: recessive idle line and a stray frame_done give no strobe
      clear_log();
      repeat (10) @(negedge clk);
      pulse_done();
      repeat (20) @(negedge clk);
      chk(s_edge.size() == 0, "R2 idle strobes", s_edge.size(), 0);

      // Frame A: P=10, frac=179 -> offset 6
      clear_log();
      bit_cycles = 12'd10; sample_frac = 8'd179;
      pat = 64'h6B38;
      d = edge_cnt + 1;
      send_bits(pat, 16, 10);
      rx_line = 1'b1;
      repeat (5) @(negedge clk);
      pulse_done();
      chk(s_edge.size() >= 16, "R4 strobe count", s_edge.size(), 16);
      if (s_edge.size() >= 16) begin
         chk(s_edge[0] - d == SYNC + 6, "R3 first sample edge", s_edge[0] - d, SYNC + 6);
         chk(s_edge[1] - s_edge[0] == 10, "R4 bit spacing", s_edge[1] - s_edge[0], 10);
         for (int i = 0; i < 16; i++) begin
            chk(s_val[i] == int'(pat[15-i]), "R5 bit value", s_val[i], int'(pat[15-i]));
            chk(s_idx[i] == i, "R5 bit index", s_idx[i], i);
         end
      end
      mingap = 1000;
      for (int i = 1; i < s_edge.size(); i++)
         if (s_edge[i] - s_edge[i-1] < mingap) mingap = s_edge[i] - s_edge[i-1];
      chk(mingap >= 2, "R6 strobe width", mingap, 2);
      clear_log();
      repeat (30) @(negedge clk);
      chk(s_edge.size() == 0, "R8 idle after done", s_edge.size(), 0);

      // Frame B: offset zero, mid-frame reprogramming, done on a sample edge
      clear_log();
      bit_cycles = 12'd8; sample_frac = 8'd0;
      d = edge_cnt + 1;
      send_bits(64'h0, 1, 8);
      send_bits(64'h5, 3, 8);
      bit_cycles = 12'd5; sample_frac = 8'd200;
      send_bits(64'h9, 4, 8);
      chk(s_edge.size() >= 6, "R9 strobes seen", s_edge.size(), 6);
      if (s_edge.size() >= 6) begin
         chk(s_edge[0] - d == SYNC, "R9 sample on reference", s_edge[0] - d, SYNC);
         chk(s_val[0] == 0, "R9 first value", s_val[0], 0);
         chk(s_idx[0] == 0, "R8 index restart", s_idx[0], 0);
         chk(s_edge[5] - s_edge[4] == 8, "R7 period frozen", s_edge[5] - s_edge[4], 8);
      end
      begin
         int tgt;
         int n_before;
         tgt = d + SYNC + 8 * 10;
         while (edge_cnt < tgt - 1) @(negedge clk);
         n_before = s_edge.size();
         frame_done = 1'b1;
         @(negedge clk);
         frame_done = 1'b0;
         chk(s_edge.size() == n_before, "R8 done suppresses sample",
             s_edge.size(), n_before);
      end
      rx_line = 1'b1;
      repeat (20) @(negedge clk);

      // Frame C: P=7, frac=128 -> offset 3, longer pseudo-random pattern
      clear_log();
      bit_cycles = 12'd7; sample_frac = 8'd128;
      pat = 64'h1D3A_95C4_E706_B2F1;
      pat[39] = 1'b0;
      d = edge_cnt + 1;
      send_bits(pat, 40, 7);
      rx_line = 1'b1;
      repeat (3) @(negedge clk);
      pulse_done();
      chk(s_edge.size() >= 40, "R4 long frame count", s_edge.size(), 40);
      if (s_edge.size() >= 40) begin
         chk(s_edge[0] - d == SYNC + 3, "R3 reference C", s_edge[0] - d, SYNC + 3);
         chk(s_idx[39] == 39, "R5 index counts all bits", s_idx[39], 39);
         chk(s_val[20] == int'(pat[19]), "R5 mid value", s_val[20], int'(pat[19]));
      end
      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule